// File: doc/BRIEF.md
# SPI Master Sequencer with Slave Attention

This block is an SPI master in mode 0. Besides the usual four wires, the slave has an active-low attention output. The slave pulls it low when it has data to return. A transaction starts when the host offers a byte or when the slave raises attention. Once started, the transaction goes on until three things are true at the same byte boundary: the host has no byte waiting, attention is released, and an external frame parser reports no incoming frame in progress (`rx_busy_i`).

The link is full duplex. Every slot exchanges one byte in each direction. When the host has nothing to send in a slot, the master shifts out an all-ones filler byte. An all-ones byte can never be mistaken for a frame delimiter. The host supplies bytes through a valid/ready port. The master takes the next byte on the final falling edge of the current one, so consecutive host bytes run with no gap in SCLK. Each received byte is returned on a one-cycle strobe. The strobe carries a flag that says whether the master was sending filler in that slot.

Top module: `spi_attn_master`

## Requirements
- R1: During reset and after it, `cs_no` is 1, `sclk_o` is 0, `mosi_o` is 1, `rx_valid_o` is 0 and `tx_ready_o` is 1.
- R2: A host byte is shifted out on `mosi_o` MSB first. `mosi_o` changes only while `sclk_o` is low, and `sclk_o` idles low.
- R3: Each SCLK half-period lasts `div_i`+1 system clocks. The first rising edge comes `div_i`+1 clocks after `cs_no` falls. `sclk_o` is high only while `cs_no` is 0.
- R4: Attention is synchronised in two stages. When `attn_ni` falls in idle, `cs_no` goes low on the third clock edge after the change. Attention that arrives during a transaction never restarts it.
- R5: `miso_i` is sampled on each rising SCLK edge, MSB first. After the eighth bit, `rx_valid_o` pulses for exactly one cycle with the byte on `rx_data_o`. `rx_filler_o` is 1 when the master sent filler in that slot and 0 when it sent a host byte.
- R6: `tx_ready_o` is high in idle and on the final falling edge of each byte. Accepted bytes follow one another with a constant rising-edge spacing of 2·(`div_i`+1) clocks. A slot that has no host byte carries filler.
- R7: When the host has no byte at a boundary, another slot follows if attention is active or `rx_busy_i` is 1. Such slots send 0xFF and never 0x7E.
- R8: `cs_no` returns to 1 only at a byte boundary, `div_i`+1 clocks after the final falling SCLK edge. Each transaction asserts chip select exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | SCLK half-period minus one, in system clocks |
| tx_valid_i | input | 1 | Host offers a byte |
| tx_data_i | input | DATA_W | Host byte |
| tx_ready_o | output | 1 | Host byte is taken on this clock |
| rx_valid_o | output | 1 | One-cycle strobe: a received byte is ready |
| rx_data_o | output | DATA_W | Received byte |
| rx_filler_o | output | 1 | Master sent filler in the slot of this byte |
| rx_busy_i | input | 1 | Parser reports an incoming frame that is not yet complete |
| attn_ni | input | 1 | Slave attention, active low, asynchronous |
| sclk_o | output | 1 | SPI clock, idles low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Slave data in |

## Verification
The critical coincidence is at a byte boundary. On that one clock the master must decide whether to take a waiting host byte, whether to insert filler for an active attention or busy indication, or whether to close the transaction. On the same clock it also completes the byte it is receiving. The bench provokes this in three ways. It raises attention and loads slave data partway through a host frame. It offers a host byte in the middle of an attention-driven filler run. It drops `rx_busy_i` just after the rising edge that ends a chosen slot. A bus-level slave model compares every MOSI byte with a queue of accepted host bytes, where filler stands in for any slot with no host byte. It also feeds what it sent into the receive scoreboard, while the slot count per transaction and the single chip-select assertion confirm where the transaction ended.

// File: rtl/spi_attn_pkg.sv
package spi_attn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spi_attn_sync.sv
module spi_attn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic attn_ni,
  output logic attn_req_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], attn_ni};
  end

  assign attn_req_o = ~q[STAGES-1];
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || tick_o)    cnt_q <= div_i;
    else                         cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  logic [DATA_W-1:0] tx_sh, rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_sh <= '1;
    else if (load_i)  tx_sh <= load_data_i;
    else if (shift_i) tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_sh <= '0;
    else if (sample_i) rx_sh <= {rx_sh[DATA_W-2:0], miso_i};
  end

  assign mosi_o    = tx_sh[DATA_W-1];
  assign rx_byte_o = rx_sh;
endmodule

// File: rtl/spi_attn_master.sv
module spi_attn_master
  import spi_attn_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_filler_o,
  input  logic              rx_busy_i,
  input  logic              attn_ni,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] FILL = '1;  // all ones: never a delimiter

  seq_state_e       state_q;
  logic             ph_q, sclk_q, cs_n_q, fill_q;
  logic [CNT_W-1:0] bit_q;
  logic             rxv_q, rxf_q;
  logic [DATA_W-1:0] rxd_q;

  logic attn_req, tick, start, more, last_fall;
  logic load, shift, sample;
  logic [DATA_W-1:0] load_data, rx_byte;

  spi_attn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .attn_ni, .attn_req_o(attn_req)
  );

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .en_i(state_q != ST_IDLE), .div_i, .tick_o(tick)
  );

  always_comb begin
    start     = tx_valid_i || attn_req;
    more      = tx_valid_i || attn_req || rx_busy_i;
    last_fall = (state_q == ST_XFER) && tick && ph_q && (bit_q == LAST_BIT);
    load      = ((state_q == ST_IDLE) && start) || (last_fall && more);
    load_data = tx_valid_i ? tx_data_i : FILL;
    shift     = (state_q == ST_XFER) && tick && ph_q && (bit_q != LAST_BIT);
    sample    = (state_q == ST_XFER) && tick && !ph_q;
  end

  assign tx_ready_o = (state_q == ST_IDLE) || last_fall;

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i(load), .load_data_i(load_data),
    .shift_i(shift), .sample_i(sample),
    .miso_i, .mosi_o, .rx_byte_o(rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      fill_q  <= 1'b0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_XFER;
          cs_n_q  <= 1'b0;
          ph_q    <= 1'b0;
          bit_q   <= '0;
          fill_q  <= !tx_valid_i;
        end
        ST_XFER: if (tick) begin
          if (!ph_q) begin
            ph_q   <= 1'b1;
            sclk_q <= 1'b1;
          end else begin
            ph_q   <= 1'b0;
            sclk_q <= 1'b0;
            if (bit_q == LAST_BIT) begin
              bit_q <= '0;
              if (more) fill_q  <= !tx_valid_i;
              else      state_q <= ST_TAIL;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_TAIL: if (tick) begin
          state_q <= ST_IDLE;
          cs_n_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxv_q <= 1'b0;
      rxd_q <= '0;
      rxf_q <= 1'b0;
    end else begin
      rxv_q <= last_fall;
      if (last_fall) begin
        rxd_q <= rx_byte;
        rxf_q <= fill_q;
      end
    end
  end

  assign sclk_o      = sclk_q;
  assign cs_no       = cs_n_q;
  assign rx_valid_o  = rxv_q;
  assign rx_data_o   = rxd_q;
  assign rx_filler_o = rxf_q;
endmodule

// File: rtl/spi_attn_master_chk.sv
module spi_attn_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o
);
  p_sclk_in_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  p_mosi_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  p_cs_fall_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sclk_o);

  p_accept_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !cs_no);

  p_release_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (!$past(sclk_o) && !$past(sclk_o, 2)));

  p_rx_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_rx_in_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !cs_no);
endmodule

bind spi_attn_master spi_attn_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o),
  .sclk_o(sclk_o), .cs_no(cs_no), .mosi_o(mosi_o)
);

// File: tb/spi_attn_master_tb.sv
module spi_attn_master_tb;
  localparam int HALF = 4;  // div_i = 3

  typedef struct {logic [7:0] d; logic f;} item_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] div_i = 8'd3;
  logic tx_valid = 1'b0, rx_busy = 1'b0, attn_n = 1'b1, s_miso = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_filler, sclk_o, cs_no, mosi_o;
  logic [7:0] rx_data;

  spi_attn_master u_dut (
    .clk_i(clk), .rst_ni, .div_i, .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_filler_o(rx_filler), .rx_busy_i(rx_busy), .attn_ni(attn_n),
    .sclk_o, .cs_no, .mosi_o, .miso_i(s_miso)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int slots = 0, cs_falls = 0, gap_bad = 0;
  int cs_fall_cyc = 0, first_rise_cyc = 0, last_rise_cyc = 0, last_fall_cyc = 0, tail = 0;
  bit first_rise = 1'b0;
  logic [7:0] slave_q[$];
  item_t exp_tx[$], exp_rx[$];
  logic [7:0] s_cur = 8'hFF, s_tx = 8'hFF, s_rx = '0;
  int s_bits = 0;
  logic prev_rxv = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // slave bus model
  task automatic s_load();
    s_cur = (slave_q.size() != 0) ? slave_q.pop_front() : 8'hFF;
    s_tx = s_cur;
    s_miso = s_tx[7];
    s_bits = 0;
    if (slave_q.size() == 0) attn_n = 1'b1;
  endtask

  always @(negedge cs_no) begin
    cs_falls++; slots = 0; cs_fall_cyc = cyc; first_rise = 1'b1;
    s_load();
  end

  always @(posedge cs_no) tail = cyc - last_fall_cyc;

  always @(posedge sclk_o) begin
    item_t e;
    if (first_rise) begin
      first_rise_cyc = cyc; first_rise = 1'b0;
    end else if (cyc - last_rise_cyc != 2 * HALF) gap_bad++;
    last_rise_cyc = cyc;
    s_rx = {s_rx[6:0], mosi_o};
    s_bits++;
    if (s_bits == 8) begin
      slots++;
      if (exp_tx.size() != 0) e = exp_tx.pop_front();
      else begin e.d = 8'hFF; e.f = 1'b1; end
      if (e.f) chk(s_rx == e.d, "R7", "filler on mosi", s_rx, e.d);
      else     chk(s_rx == e.d, "R2", "host byte on mosi", s_rx, e.d);
      exp_rx.push_back('{d: s_cur, f: e.f});
    end
  end

  always @(negedge sclk_o) begin
    last_fall_cyc = cyc;
    if (s_bits == 8) s_load();
    else begin
      s_tx = {s_tx[6:0], 1'b1};
      s_miso = s_tx[7];
    end
  end

  // receive monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rx_valid) begin
        item_t e;
        chk(!prev_rxv, "R5", "rx strobe width", 2, 1);
        if (exp_rx.size() == 0) chk(1'b0, "R5", "unexpected rx byte", rx_data, 0);
        else begin
          e = exp_rx.pop_front();
          chk(rx_data == e.d, "R5", "rx data", rx_data, e.d);
          chk(rx_filler == e.f, "R5", "rx filler flag", rx_filler, e.f);
        end
      end
      prev_rxv = rx_valid;
    end
  end

  task automatic send(input logic [7:0] b);
    tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    exp_tx.push_back('{d: b, f: 1'b0});
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic slave_push(input logic [7:0] b);
    slave_q.push_back(b);
    attn_n = 1'b0;
  endtask

  task automatic wait_end();
    while (cs_no) @(negedge clk);
    while (!cs_no) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int cf;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_no == 1'b1, "R1", "cs_no", cs_no, 1);
    chk(sclk_o == 1'b0, "R1", "sclk_o", sclk_o, 0);
    chk(mosi_o == 1'b1, "R1", "mosi_o", mosi_o, 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid_o", rx_valid, 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready_o", tx_ready, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_no == 1'b1 && sclk_o == 1'b0, "R1", "idle after reset", cs_no, 1);

    // single host byte
    gap_bad = 0;
    send(8'hA5); wait_end();
    chk(slots == 1, "R2", "slots", slots, 1);
    chk(first_rise_cyc - cs_fall_cyc == HALF, "R3", "lead", first_rise_cyc - cs_fall_cyc, HALF);
    chk(tail == HALF, "R8", "release delay", tail, HALF);

    // back-to-back host bytes
    cf = cs_falls; gap_bad = 0;
    send(8'h12); send(8'h7E); send(8'hC3); wait_end();
    chk(slots == 3, "R6", "slots", slots, 3);
    chk(gap_bad == 0, "R6", "rise spacing errors", gap_bad, 0);
    chk(cs_falls - cf == 1, "R8", "cs assertions", cs_falls - cf, 1);

    // attention from idle
    slave_push(8'h7E); slave_push(8'h05); slave_push(8'h41);
    repeat (2) @(negedge clk);
    chk(cs_no == 1'b1, "R4", "cs after two edges", cs_no, 1);
    @(negedge clk);
    chk(cs_no == 1'b0, "R4", "cs after three edges", cs_no, 0);
    gap_bad = 0;
    wait_end();
    chk(slots == 3, "R7", "slots", slots, 3);
    chk(gap_bad == 0, "R3", "rise spacing errors", gap_bad, 0);

    // attention mid host frame: full duplex
    cf = cs_falls;
    fork
      begin send(8'h3C); send(8'h99); end
      begin
        while (cs_no) @(negedge clk);
        repeat (10) @(negedge clk);
        slave_push(8'h5A); slave_push(8'h66); slave_push(8'h7E);
      end
    join
    wait_end();
    chk(slots == 4, "R7", "slots", slots, 4);
    chk(cs_falls - cf == 1, "R4", "no restart", cs_falls - cf, 1);

    // busy extension
    rx_busy = 1'b1;
    fork
      send(8'h81);
      begin wait (slots == 3); rx_busy = 1'b0; end
    join
    wait_end();
    chk(slots == 3, "R7", "busy slots", slots, 3);

    // host byte inside an attention run
    cf = cs_falls; gap_bad = 0;
    slave_push(8'h11); slave_push(8'h22); slave_push(8'h33); slave_push(8'h44);
    while (cs_no) @(negedge clk);
    repeat (16 * HALF + 8) @(negedge clk);
    send(8'hE7);
    wait_end();
    chk(slots == 4, "R6", "slots with late host byte", slots, 4);
    chk(gap_bad == 0, "R6", "rise spacing errors", gap_bad, 0);
    chk(cs_falls - cf == 1, "R8", "cs assertions", cs_falls - cf, 1);

    chk(exp_rx.size() == 0, "R5", "pending rx items", exp_rx.size(), 0);
    chk(exp_tx.size() == 0, "R2", "pending tx items", exp_tx.size(), 0);
    finish_run();
  end
endmodule